// File: doc/BRIEF.md
# Two-Channel Interrupt Aggregator with Summary Status Words

This block gathers the interrupt request of two storage channels. Each request is sampled into a per-channel pending flag on every clock. The flag sits at bit 11 of that channel's configuration/status word, and the two full words are available as outputs. One level-sensitive host interrupt is driven whenever either pending flag is set. The host interrupt controller that consumes it is not part of this block.

The block also builds two read-only 32-bit summary words for software. Each word packs a command byte, bus-master status bytes and pending flags into a single read. The command and status bytes are held in registers elsewhere and arrive here as plain inputs. The summary words are combinational views of those inputs and of the pending flags, so they never lag the stored registers.

Top module: `irq_sum_agg`

## Requirements
- R1: When `chan_irq[i]` is high at a rising clock edge, the pending flag of channel i (bit 11 of `cfg_word_i`) reads 1 after that edge.
- R2: When `chan_irq[i]` is low at a rising clock edge, the pending flag of channel i reads 0 after that edge.
- R3: `host_irq` is high exactly when at least one channel's pending flag is set.
- R4: In `sum_a`, bits 7:0 carry `cmd0` with bit 4 ORed with channel 0's pending flag and bit 6 ORed with channel 1's pending flag. A command bit that is already 1 stays 1.
- R5: `sum_a` bit 14 equals bit 2 of `sts1` (channel 1's bus-master interrupt bit). Bits 15:8 other than bit 14 read 0.
- R6: `sum_a` bits 23:16 equal `sts0`, and bits 31:24 equal `sts1`.
- R7: In `sum_b`, bits 7:0 carry `cmd1` with bit 4 ORed with channel 1's pending flag, and bits 23:16 equal `sts1`. Bits 15:8 and 31:24 read 0.
- R8: While `rst_n` is low, both pending flags are 0 and `host_irq` is low, whatever `chan_irq` does. In each `cfg_word_i`, every bit other than bit 11 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_irq | input | 2 | Interrupt request per channel, bit i for channel i |
| cmd0 | input | 8 | Channel 0 bus-master command byte |
| cmd1 | input | 8 | Channel 1 bus-master command byte |
| sts0 | input | 8 | Channel 0 bus-master status byte |
| sts1 | input | 8 | Channel 1 bus-master status byte |
| cfg_word0 | output | 32 | Channel 0 configuration/status word, pending flag at bit 11 |
| cfg_word1 | output | 32 | Channel 1 configuration/status word, pending flag at bit 11 |
| host_irq | output | 1 | Level host interrupt |
| sum_a | output | 32 | Summary word covering both channels |
| sum_b | output | 32 | Summary word for channel 1 |

## Verification
Random request pairs and random command and status bytes are mixed with directed cases.
- All-ones command bytes with both flags clear show whether a pending flag replaces a command bit or is ORed onto it.
- Status bytes carrying a single bit 2, or every bit except bit 2, separate the bit-14 copy from a plain byte placement.
- Asserting one channel's request at a time shows whether the two channels' flags land in their own positions.
- Holding the requests high through reset shows whether reset takes priority over sampling.

// File: rtl/irq_sum_agg.sv
module irq_sum_agg #(
  parameter int CH_N      = 2,
  parameter int BYTE_W    = 8,
  parameter int WORD_W    = 32,
  parameter int PEND_BIT  = 11,
  parameter int BM_IRQ_B  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_N-1:0]   chan_irq,
  input  logic [BYTE_W-1:0] cmd0,
  input  logic [BYTE_W-1:0] cmd1,
  input  logic [BYTE_W-1:0] sts0,
  input  logic [BYTE_W-1:0] sts1,
  output logic [WORD_W-1:0] cfg_word0,
  output logic [WORD_W-1:0] cfg_word1,
  output logic              host_irq,
  output logic [WORD_W-1:0] sum_a,
  output logic [WORD_W-1:0] sum_b
);
  localparam int OWN_FLAG  = 4;
  localparam int PEER_FLAG = 6;
  localparam int PEER_BM   = 14;
  localparam int STS_LO    = 16;
  localparam int STS_HI    = 24;

  logic [CH_N-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= chan_irq;
  end

  always_comb begin
    cfg_word0 = '0;
    cfg_word1 = '0;
    cfg_word0[PEND_BIT] = pend_q[0];
    cfg_word1[PEND_BIT] = pend_q[1];
  end

  assign host_irq = cfg_word0[PEND_BIT] | cfg_word1[PEND_BIT];

  always_comb begin
    sum_a = '0;
    sum_a[BYTE_W-1:0] = cmd0;
    sum_a[OWN_FLAG]  = cmd0[OWN_FLAG]  | cfg_word0[PEND_BIT];
    sum_a[PEER_FLAG] = cmd0[PEER_FLAG] | cfg_word1[PEND_BIT];
    sum_a[PEER_BM]   = sts1[BM_IRQ_B];
    sum_a[STS_LO +: BYTE_W] = sts0;
    sum_a[STS_HI +: BYTE_W] = sts1;
  end

  always_comb begin
    sum_b = '0;
    sum_b[BYTE_W-1:0] = cmd1;
    sum_b[OWN_FLAG] = cmd1[OWN_FLAG] | cfg_word1[PEND_BIT];
    sum_b[STS_LO +: BYTE_W] = sts1;
  end
endmodule

// File: rtl/irq_sum_agg_chk.sv
module irq_sum_agg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  chan_irq,
  input logic [7:0]  sts1,
  input logic [31:0] cfg_word0,
  input logic [31:0] cfg_word1,
  input logic        host_irq,
  input logic [31:0] sum_a,
  input logic [31:0] sum_b
);
  a_r1_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    chan_irq[0] |=> cfg_word0[11]);
  a_r1_flag_set_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    chan_irq[1] |=> cfg_word1[11]);
  a_r2_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_irq[0] |=> !cfg_word0[11]);
  a_r3_host_on: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq != 2'b00) |=> host_irq);
  a_r3_host_off: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_irq == 2'b00) |=> !host_irq);
  a_r4_own_flag: assert property (@(posedge clk) disable iff (!rst_n)
    chan_irq[0] |=> sum_a[4]);
  a_r4_peer_flag: assert property (@(posedge clk) disable iff (!rst_n)
    chan_irq[1] |=> (sum_a[6] && sum_b[4]));
  a_r5_peer_bm: assert property (@(posedge clk) disable iff (!rst_n)
    sum_a[14] == sts1[2]);
  a_r6_r7_sts_match: assert property (@(posedge clk) disable iff (!rst_n)
    sum_a[31:24] == sum_b[23:16]);
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!host_irq && !cfg_word0[11] && !cfg_word1[11]));
endmodule

bind irq_sum_agg irq_sum_agg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_irq(chan_irq), .sts1(sts1),
  .cfg_word0(cfg_word0), .cfg_word1(cfg_word1), .host_irq(host_irq),
  .sum_a(sum_a), .sum_b(sum_b)
);

// File: tb/tb_irq_sum_agg.sv
module tb_irq_sum_agg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  chan_irq = '0;
  logic [7:0]  cmd0 = '0, cmd1 = '0, sts0 = '0, sts1 = '0;
  logic [31:0] cfg_word0, cfg_word1, sum_a, sum_b;
  logic        host_irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  irq_sum_agg dut (
    .clk(clk), .rst_n(rst_n), .chan_irq(chan_irq), .cmd0(cmd0), .cmd1(cmd1),
    .sts0(sts0), .sts1(sts1), .cfg_word0(cfg_word0), .cfg_word1(cfg_word1),
    .host_irq(host_irq), .sum_a(sum_a), .sum_b(sum_b)
  );

  function automatic logic [31:0] exp_a(input logic [7:0] c0, s0, s1, input logic [1:0] p);
    logic [31:0] w;
    w = {s1, s0, 1'b0, s1[2], 6'b0, c0};
    w[4] = w[4] | p[0];
    w[6] = w[6] | p[1];
    return w;
  endfunction

  function automatic logic [31:0] exp_b(input logic [7:0] c1, s1, input logic [1:0] p);
    logic [31:0] w;
    w = {8'h00, s1, 8'h00, c1};
    w[4] = w[4] | p[1];
    return w;
  endfunction

  function automatic logic [31:0] exp_cfg(input logic p);
    logic [31:0] w;
    w = '0;
    w[11] = p;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input logic [1:0] p);
    chk("R1/R2 cfg_word0", cfg_word0, exp_cfg(p[0]));
    chk("R1/R2 cfg_word1", cfg_word1, exp_cfg(p[1]));
    chk("R3 host_irq", {31'b0, host_irq}, {31'b0, |p});
    chk("R4/R5/R6 sum_a", sum_a, exp_a(cmd0, sts0, sts1, p));
    chk("R7 sum_b", sum_b, exp_b(cmd1, sts1, p));
  endtask

  task automatic step(input logic [1:0] irq, input logic [7:0] c0, c1, s0, s1);
    @(negedge clk);
    chan_irq = irq; cmd0 = c0; cmd1 = c1; sts0 = s0; sts1 = s1;
    @(posedge clk);
    #1;
    check_all(irq);
  endtask

  initial begin
    void'($urandom(32'd1234));
    chan_irq = 2'b11; cmd0 = 8'h00; cmd1 = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    // R8: requests held high during reset do not reach the flags
    check_all(2'b00);
    @(negedge clk) rst_n = 1'b1;
    // R4 and R7: command bits already set stay set
    step(2'b00, 8'hFF, 8'hFF, 8'h00, 8'h00);
    step(2'b11, 8'hFF, 8'hFF, 8'h00, 8'h00);
    // R5: isolated bus-master interrupt bit, then its complement
    step(2'b00, 8'h00, 8'h00, 8'h00, 8'h04);
    step(2'b00, 8'h00, 8'h00, 8'hFB, 8'hFB);
    // R1, R2, R4: one channel at a time, then both cleared
    step(2'b01, 8'h00, 8'h00, 8'hA5, 8'h5A);
    step(2'b10, 8'h00, 8'h00, 8'h5A, 8'hA5);
    step(2'b00, 8'h00, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < 400; i++)
      step(2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    // R8: reset asserted mid-run clears the flags
    @(negedge clk); chan_irq = 2'b11; rst_n = 1'b0;
    @(posedge clk); #1;
    check_all(2'b00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_all(2'b11);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule